// File: doc/BRIEF.md
# GPIO Pin Bank with Per-Pin Event Detection

This block is a memory-mapped bank of general-purpose I/O pins. The pin count is a parameter, with a default of 8. Each pin owns a 4 KB window holding four 32-bit registers:

- **pad control:** the output enable for the pad.
- **pad data:** the driven value, plus the synchronised input read back.
- **event setup:** detection mode, polarity, latch enable, interrupt enable and a stored target field.
- **event flag:** a sticky bit that records a detected event.

Every pad input passes through a two-flop synchroniser before any detection logic sees it. The detection logic watches for a level, a rising edge, a falling edge or either edge. A detected event sets the pin's sticky flag. Software clears the flag by writing a zero to it. One registered interrupt line is high while any pin has its flag set and its interrupt enabled.

The register port is a simple single-cycle bus and is always ready. A write completes on the clock edge where `bus_sel` and `bus_wr` are both high. A read is requested by `bus_sel` high with `bus_wr` low. On the next cycle `bus_rvalid` is high and `bus_rdata` holds the word. The bus has no back-pressure, so a request may be issued on every cycle. The pad signals and the interrupt are plain level pins.

Top module: `gpio_bank`

## Requirements
- R1: Pin p's registers start at byte address p*0x1000. Pad control is at +0x0, pad data at +0x4, event setup at +0x8 and event flag at +0xC. Bit 9 of pad control is stored and drives `pad_oe[p]`. All other pad-control bits read 0.
- R2: Pad data bit 1 is read/write and drives `pad_out[p]`. Pad data bit 0 is read-only and returns `pad_in[p]` after a two-flop synchroniser. Writes to bit 0 have no effect, and bits 31:2 read 0.
- R3: Event setup bits [3:2] choose the detection mode. The encodings are 00 level, 01 rising, 10 falling and 11 either edge. In mode 01 only a 0-to-1 change of the synchronised input sets the flag.
- R4: In mode 10 only a 1-to-0 change of the synchronised input sets the flag.
- R5: In mode 11 either change sets the flag, whatever the value of the polarity bit. In all edge modes the polarity bit (event setup bit 1) has no effect.
- R6: In mode 00, polarity 1 means the flag is set while the synchronised input is 1, and polarity 0 means it is set while the input is 0. The flag is set again on every cycle the active level is present, so a clear does not take effect while that level persists.
- R7: Writing the event flag register with bit 0 = 0 clears the flag. Writing it with bit 0 = 1 leaves the flag unchanged.
- R8: With event setup bit 4 (latch enable) at 0, no event sets the flag.
- R9: The signal `irq` is registered. It is the OR over all pins of (flag AND event setup bit 0) and follows that OR one cycle later. A pin with bit 0 = 0 still latches its flag but does not raise `irq`. A rising edge on `pad_in` in an enabled edge mode raises `irq` after exactly four clock edges.
- R10: Event setup bits [7:0] read back exactly as written. Bits [7:5] are a stored target field with no other effect. Bits 31:8 read 0.
- R11: An address whose pin index is at or above the pin count, or whose offset within the window is not one of 0x0, 0x4, 0x8 or 0xC, reads as 0. Writes to such an address change nothing.
- R12: Reset clears every register. After reset all reads return 0, and `pad_oe`, `pad_out`, `irq` and `bus_rvalid` are 0.
- R13: A read request in cycle n gives `bus_rvalid` = 1 and the addressed word on `bus_rdata` in cycle n+1. `bus_rvalid` is 0 in the cycle after any non-read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (16) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| pad_in | input | NUM_PINS (8) | Asynchronous pad inputs |
| pad_out | output | NUM_PINS (8) | Pad drive values |
| pad_oe | output | NUM_PINS (8) | Pad output enables |
| irq | output | 1 | Combined registered interrupt |

## Verification
Each fault shows up at the ports within a few cycles:

- **Wrong edge history:** a stale previous-sample register shows as a flag read back as 1 after an edge of the wrong direction. It also shows as a missing flag about three cycles after the right one.
- **Missing synchroniser stage:** this moves the rise of `irq` earlier than the fourth clock edge after the pad change.
- **Wrong clear priority:** a level-mode flag that reads 0 right after a clear while the level persists.
- **Clear on write-one:** a flag that reads 0 after writing 1 to it.
- **Address aliasing:** a write to an out-of-range pin or a misaligned offset changes `pad_oe` of a real pin at once.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int REG_W    = 32;
  localparam int OFFSET_W = 12;  // 4 KB window per pin

  // Bit positions that software decodes
  localparam int CFG_OE_BIT  = 9;
  localparam int IO_IN_BIT   = 0;
  localparam int IO_OUT_BIT  = 1;
  localparam int FLAG_BIT    = 0;
  localparam int SETUP_W     = 8;

  typedef enum logic [1:0] {
    DET_LEVEL = 2'b00,
    DET_RISE  = 2'b01,
    DET_FALL  = 2'b10,
    DET_BOTH  = 2'b11
  } det_mode_e;

  // Register selected by offset bits [3:2]
  typedef enum logic [1:0] {
    REG_PADCTL = 2'b00,
    REG_PADDAT = 2'b01,
    REG_SETUP  = 2'b10,
    REG_FLAG   = 2'b11
  } reg_kind_e;

  // Event setup register, bits [7:0]
  typedef struct packed {
    logic [2:0] target;   // [7:5] stored only
    logic       latch_en; // [4]
    det_mode_e  mode;     // [3:2]
    logic       pol;      // [1]
    logic       irq_en;   // [0]
  } setup_t;

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

  AST_SYNC_RESET_LOW: assert property (@(posedge clk)
    $rose(rst_n) |-> sync_out == '0) else $error("sync not cleared"); // R12

endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 16
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic                hit,
  output reg_kind_e           kind,
  output logic [NUM_PINS-1:0] pin_sel
);

  localparam int PIN_IDX_W = ADDR_W - OFFSET_W;

  logic [PIN_IDX_W-1:0] pin_idx;
  logic [OFFSET_W-1:0]  ofs;
  logic                 ofs_ok;
  logic                 in_range;

  assign pin_idx  = addr[ADDR_W-1:OFFSET_W];
  assign ofs      = addr[OFFSET_W-1:0];
  // Only word offsets 0x0..0xC are mapped
  assign ofs_ok   = (ofs[OFFSET_W-1:4] == '0) && (ofs[1:0] == 2'b00);
  assign in_range = {1'b0, pin_idx} < (PIN_IDX_W+1)'(NUM_PINS);
  assign hit      = ofs_ok && in_range;
  assign kind     = reg_kind_e'(ofs[3:2]);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_sel
    assign pin_sel[p] = hit && (pin_idx == PIN_IDX_W'(p));
  end

  always_comb begin
    AST_SEL_ONEHOT: assert ($onehot0(pin_sel)) else $error("pin select overlap"); // R11
  end

endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
  import gpio_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,    // write addressed to this pin
  input  reg_kind_e        kind,
  input  logic             wr_oe,     // write data bit 9
  input  logic             wr_out,    // write data bit 1
  input  logic [SETUP_W-1:0] wr_setup, // write data bits [7:0]
  input  logic             pin_s,     // synchronised pad input
  output logic [REG_W-1:0] rd_word,
  output logic             pad_out,
  output logic             pad_oe,
  output logic             irq_req
);

  logic   oe_q;
  logic   out_q;
  setup_t setup_q;
  logic   flag_q;
  logic   prev_q;
  logic   evt;
  logic   do_clr;
  logic   flag_d;

  // Event detection on the synchronised input
  always_comb begin
    unique case (setup_q.mode)
      DET_LEVEL: evt = (pin_s == setup_q.pol);
      DET_RISE:  evt = pin_s && !prev_q;
      DET_FALL:  evt = !pin_s && prev_q;
      default:   evt = pin_s ^ prev_q;
    endcase
  end

  // Clear on write-zero; a present event has priority
  assign do_clr = wr_hit && (kind == REG_FLAG) && !wr_setup[FLAG_BIT];
  assign flag_d = (flag_q && !do_clr) || (evt && setup_q.latch_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q    <= 1'b0;
      out_q   <= 1'b0;
      setup_q <= '0;
      flag_q  <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      prev_q <= pin_s;
      flag_q <= flag_d;
      if (wr_hit && kind == REG_PADCTL) oe_q    <= wr_oe;
      if (wr_hit && kind == REG_PADDAT) out_q   <= wr_out;
      if (wr_hit && kind == REG_SETUP)  setup_q <= setup_t'(wr_setup);
    end
  end

  always_comb begin
    rd_word = '0;
    unique case (kind)
      REG_PADCTL: rd_word[CFG_OE_BIT] = oe_q;
      REG_PADDAT: begin
        rd_word[IO_OUT_BIT] = out_q;
        rd_word[IO_IN_BIT]  = pin_s;
      end
      REG_SETUP:  rd_word[SETUP_W-1:0] = setup_q;
      default:    rd_word[FLAG_BIT] = flag_q;
    endcase
  end

  assign pad_out = out_q;
  assign pad_oe  = oe_q;
  assign irq_req = flag_q && setup_q.irq_en;

  AST_OE_TRACKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && kind == REG_PADCTL) |=> (pad_oe == $past(wr_oe))) else $error("oe"); // R1
  AST_NO_LATCH_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!setup_q.latch_en && !flag_q) |=> !flag_q) else $error("latch off"); // R8
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (do_clr && !(evt && setup_q.latch_en)) |=> !flag_q) else $error("clear"); // R7
  AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_q.mode == DET_LEVEL && setup_q.latch_en && pin_s == setup_q.pol) |=> flag_q)
    else $error("level"); // R6
  AST_EITHER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_q.mode == DET_BOTH && setup_q.latch_en && pin_s != prev_q) |=> flag_q)
    else $error("both"); // R5

endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] req,
  output logic                irq
);

  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |req;
  end

  assign irq = irq_q;

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |=> !irq) else $error("irq without request"); // R9
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |=> irq) else $error("irq missing"); // R9

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [REG_W-1:0]    bus_wdata,
  output logic [REG_W-1:0]    bus_rdata,
  output logic                bus_rvalid,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic                irq
);

  logic                hit;
  reg_kind_e           kind;
  logic [NUM_PINS-1:0] pin_sel;
  logic [NUM_PINS-1:0] pin_s;
  logic [NUM_PINS-1:0] irq_req;
  logic [REG_W-1:0]    rd_words [NUM_PINS];
  logic [REG_W-1:0]    rd_next;
  logic [REG_W-1:0]    rdata_q;
  logic                rvalid_q;
  logic                unused_wdata;

  assign unused_wdata = ^{bus_wdata[REG_W-1:CFG_OE_BIT+1], bus_wdata[CFG_OE_BIT-1:SETUP_W]};

  gpio_addr_decode #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_decode (
    .addr    (bus_addr),
    .hit     (hit),
    .kind    (kind),
    .pin_sel (pin_sel)
  );

  gpio_sync2 #(.WIDTH(NUM_PINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (pin_s)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_pin_slice u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit   (bus_sel && bus_wr && pin_sel[p]),
      .kind     (kind),
      .wr_oe    (bus_wdata[CFG_OE_BIT]),
      .wr_out   (bus_wdata[IO_OUT_BIT]),
      .wr_setup (bus_wdata[SETUP_W-1:0]),
      .pin_s    (pin_s[p]),
      .rd_word  (rd_words[p]),
      .pad_out  (pad_out[p]),
      .pad_oe   (pad_oe[p]),
      .irq_req  (irq_req[p])
    );
  end

  gpio_irq_merge #(.NUM_PINS(NUM_PINS)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (irq_req),
    .irq   (irq)
  );

  // Read mux: unselected pins contribute zero
  always_comb begin
    rd_next = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (pin_sel[p]) rd_next = rd_next | rd_words[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_sel && !bus_wr;
      if (bus_sel && !bus_wr) rdata_q <= rd_next;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

  AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr) |=> bus_rvalid) else $error("rvalid missing"); // R13
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> !bus_rvalid) else $error("spurious rvalid"); // R13
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && !hit) |=> (bus_rdata == '0)) else $error("unmapped read"); // R11

endmodule

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;

  localparam int NP = 8;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          bus_rvalid;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out;
  logic [NP-1:0] pad_oe;
  logic          irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  gpio_bank #(.NUM_PINS(NP), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq(irq)
  );

  localparam logic [11:0] O_CTL = 12'h000, O_DAT = 12'h004, O_SET = 12'h008, O_FLG = 12'h00C;

  function automatic logic [AW-1:0] ra(int pin, logic [11:0] ofs);
    return AW'(pin * 32'h1000) + AW'(ofs);
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic expect_reg(string tag, logic [AW-1:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic t_reset();
    check("R12 irq", 32'(irq), 0);
    check("R12 pad_oe", 32'(pad_oe), 0);
    check("R12 pad_out", 32'(pad_out), 0);
    check("R12 rvalid", 32'(bus_rvalid), 0);
    expect_reg("R12 padctl", ra(0, O_CTL), 0);
    expect_reg("R12 setup", ra(5, O_SET), 0);
    expect_reg("R12 flag", ra(7, O_FLG), 0);
  endtask

  task automatic t_map();
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ra(0, O_DAT);
    @(negedge clk);
    check("R13 rvalid after read", 32'(bus_rvalid), 1);
    bus_sel = 1'b0;
    @(negedge clk);
    check("R13 rvalid idle", 32'(bus_rvalid), 0);
    wr(ra(2, O_CTL), 32'hFFFF_FFFF);
    check("R1 pad_oe", 32'(pad_oe), 32'h4);
    expect_reg("R1 padctl readback", ra(2, O_CTL), 32'h200);
    wr(ra(2, O_DAT), 32'hFFFF_FFFF);
    check("R2 pad_out", 32'(pad_out), 32'h4);
    expect_reg("R2 paddat in=0", ra(2, O_DAT), 32'h2);
    pad_in[2] = 1'b1;
    idle(3);
    expect_reg("R2 paddat in=1", ra(2, O_DAT), 32'h3);
    wr(ra(2, O_DAT), 32'h0000_0001);
    expect_reg("R2 bit0 read-only", ra(2, O_DAT), 32'h1);
    check("R2 pad_out cleared", 32'(pad_out), 0);
    wr(ra(3, O_SET), 32'hFFFF_FFFF);
    expect_reg("R10 setup readback", ra(3, O_SET), 32'hFF);
    wr(ra(3, O_SET), 32'hE0);
    expect_reg("R10 target only", ra(3, O_SET), 32'hE0);
    check("R10 target no irq", 32'(irq), 0);
    wr(ra(3, O_SET), 0);
  endtask

  task automatic t_rise();
    wr(ra(0, O_SET), 32'h15);
    wr(ra(0, O_FLG), 0);
    pad_in[0] = 1'b1;
    idle(3);
    check("R9 irq not before 4th edge", 32'(irq), 0);
    idle(1);
    check("R9 irq at 4th edge", 32'(irq), 1);
    expect_reg("R3 rise flag", ra(0, O_FLG), 1);
    wr(ra(0, O_FLG), 1);
    expect_reg("R7 write-one keeps", ra(0, O_FLG), 1);
    wr(ra(0, O_FLG), 0);
    expect_reg("R7 write-zero clears", ra(0, O_FLG), 0);
    idle(1);
    check("R9 irq drops", 32'(irq), 0);
    pad_in[0] = 1'b0;
    idle(6);
    expect_reg("R3 fall ignored in rise mode", ra(0, O_FLG), 0);
  endtask

  task automatic t_fall();
    wr(ra(0, O_SET), 32'h19);
    wr(ra(0, O_FLG), 0);
    pad_in[0] = 1'b1;
    idle(6);
    expect_reg("R4 rise ignored in fall mode", ra(0, O_FLG), 0);
    pad_in[0] = 1'b0;
    idle(6);
    expect_reg("R4 fall flag", ra(0, O_FLG), 1);
    wr(ra(0, O_FLG), 0);
  endtask

  task automatic t_both();
    wr(ra(0, O_SET), 32'h1D);
    wr(ra(0, O_FLG), 0);
    pad_in[0] = 1'b1;
    idle(6);
    expect_reg("R5 both rise", ra(0, O_FLG), 1);
    wr(ra(0, O_FLG), 0);
    pad_in[0] = 1'b0;
    idle(6);
    expect_reg("R5 both fall", ra(0, O_FLG), 1);
    wr(ra(0, O_SET), 32'h1F);
    wr(ra(0, O_FLG), 0);
    pad_in[0] = 1'b1;
    idle(6);
    expect_reg("R5 polarity ignored", ra(0, O_FLG), 1);
    pad_in[0] = 1'b0;
    idle(6);
    wr(ra(0, O_FLG), 0);
  endtask

  task automatic t_latch_mask();
    wr(ra(0, O_SET), 32'h0D);
    wr(ra(0, O_FLG), 0);
    pad_in[0] = 1'b1;
    idle(6);
    expect_reg("R8 no latch rise", ra(0, O_FLG), 0);
    check("R8 no irq", 32'(irq), 0);
    pad_in[0] = 1'b0;
    idle(6);
    expect_reg("R8 no latch fall", ra(0, O_FLG), 0);
    wr(ra(0, O_SET), 32'h1C);
    pad_in[0] = 1'b1;
    idle(6);
    expect_reg("R9 masked still latches", ra(0, O_FLG), 1);
    check("R9 masked no irq", 32'(irq), 0);
    wr(ra(0, O_SET), 32'h1D);
    idle(2);
    check("R9 unmask raises irq", 32'(irq), 1);
    wr(ra(0, O_FLG), 0);
    idle(2);
    check("R9 irq after clear", 32'(irq), 0);
  endtask

  task automatic t_level();
    wr(ra(0, O_SET), 32'h13);
    idle(4);
    expect_reg("R6 active-high set", ra(0, O_FLG), 1);
    wr(ra(0, O_FLG), 0);
    expect_reg("R6 clear blocked by level", ra(0, O_FLG), 1);
    pad_in[0] = 1'b0;
    idle(4);
    wr(ra(0, O_FLG), 0);
    expect_reg("R6 clear after level gone", ra(0, O_FLG), 0);
    wr(ra(0, O_SET), 32'h11);
    idle(4);
    expect_reg("R6 active-low set", ra(0, O_FLG), 1);
    pad_in[0] = 1'b1;
    idle(4);
    wr(ra(0, O_FLG), 0);
    expect_reg("R6 active-low cleared", ra(0, O_FLG), 0);
    wr(ra(0, O_SET), 0);
  endtask

  task automatic t_bad_addr();
    wr(ra(0, 12'h002), 32'h200);
    check("R11 misaligned write ignored", 32'(pad_oe), 32'h4);
    expect_reg("R11 pin0 padctl untouched", ra(0, O_CTL), 0);
    wr(ra(8, O_CTL), 32'h200);
    check("R11 out-of-range write ignored", 32'(pad_oe), 32'h4);
    expect_reg("R11 out-of-range read", ra(8, O_CTL), 0);
    expect_reg("R11 unmapped offset read", ra(2, 12'h010), 0);
    expect_reg("R11 high pin read", ra(15, O_SET), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_rise();
    t_fall();
    t_both();
    t_latch_mask();
    t_level();
    t_bad_addr();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule